// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level translation table from memory to do so. A requester presents the virtual address and the current table base value through a valid/ready handshake. The walker then issues one or two word reads on a request/response memory port, which may have any latency. It decodes each returned descriptor. At the end it reports the physical address, the page kind, the two access-permission bits and the cacheable and bufferable flags. If the walk fails, it reports a fault together with the level that failed.

A first-level descriptor can end the walk in one of two ways: it can map a 1 MB section directly, or it can be empty. It can also point to a second-level table. That table is either a coarse table of 256 entries or a fine table of 1024 entries. A second-level descriptor maps a 64 KB, 4 KB or 1 KB page, or it is empty. The block handles one walk at a time.

Top module: `ptw_top`

## Requirements
- R1: The first read of a walk goes to address {tbase[31:14], va[31:20], 2'b00}. Bits [13:0] of the table base have no effect.
- R2: A first-level descriptor with low bits 00 ends the walk with fault=1 and fault_lvl=0. No second read is made.
- R3: A first-level descriptor with low bits 10 is a section. The walk makes no second read. It returns pa={desc[31:20], va[19:0]}, kind=0, ap=desc[11:10], cacheable=desc[3] and bufferable=desc[2].
- R4: A first-level descriptor with low bits 01 selects a coarse table. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R5: A first-level descriptor with low bits 11 selects a fine table. The second read goes to {desc[31:12], va[19:10], 2'b00}.
- R6: A second-level descriptor with low bits 00 ends the walk with fault=1 and fault_lvl=1.
- R7: A second-level descriptor with low bits 01 is a large page. It returns pa={desc[31:16], va[15:0]} and kind=1.
- R8: A second-level descriptor with low bits 10 is a small page. It returns pa={desc[31:12], va[11:0]} and kind=2.
- R9: A second-level descriptor with low bits 11 is a tiny page. It returns pa={desc[31:10], va[9:0]} and kind=3. For every second-level page, ap=desc[5:4], cacheable=desc[3] and bufferable=desc[2].
- R10: req_ready is high only when no walk is in flight. While mem_req_valid waits for mem_req_ready, the request stays asserted and its address does not change.
- R11: Every accepted request produces exactly one done pulse, one cycle long. On a fault, pa, kind, ap, cacheable, bufferable are all zero. When there is no fault, fault_lvl is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| req_tbase | input | 32 | First-level table base (bits [31:14] used) |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts read request |
| mem_req_addr | output | 32 | Word address of descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Translation fault |
| fault_lvl | output | 1 | Faulting level: 0 first, 1 second |
| res_pa | output | 32 | Physical address |
| res_kind | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| res_ap | output | 2 | Access-permission bits |
| res_cacheable | output | 1 | Cacheable flag |
| res_bufferable | output | 1 | Bufferable flag |

## Verification
A wrong walker state shows up at the memory port. Within one cycle of the descriptor response it appears as a second read that should not happen, as a missing one, or as a read at the wrong address. The bench compares every read address against the reference model at the moment of its handshake. A mis-decoded descriptor appears on the done pulse as a wrong page kind, a wrong offset splice or a wrong fault level. That pulse comes one cycle after the last response, so every walk is checked field by field as soon as it ends.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int AW          = 32;
    localparam int DW          = 32;
    localparam int L1_BASE_LSB = 14;
    localparam int L1_IDX_LSB  = 20;
    localparam int L1_IDX_W    = AW - L1_IDX_LSB;
    localparam int CRS_BASE_LSB = 10;
    localparam int CRS_IDX_LSB  = 12;
    localparam int CRS_IDX_W    = L1_IDX_LSB - CRS_IDX_LSB;
    localparam int FIN_BASE_LSB = 12;
    localparam int FIN_IDX_LSB  = 10;
    localparam int FIN_IDX_W    = L1_IDX_LSB - FIN_IDX_LSB;
    localparam int SEC_SHIFT   = 20;
    localparam int LRG_SHIFT   = 16;
    localparam int SML_SHIFT   = 12;
    localparam int TNY_SHIFT   = 10;

    typedef enum logic [1:0] {
        L1_EMPTY   = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_EMPTY = 2'b00,
        L2_LARGE = 2'b01,
        L2_SMALL = 2'b10,
        L2_TINY  = 2'b11
    } l2_kind_e;

    typedef enum logic [1:0] {
        PG_SECTION = 2'd0,
        PG_LARGE   = 2'd1,
        PG_SMALL   = 2'd2,
        PG_TINY    = 2'd3
    } page_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT
    } walk_st_e;

    typedef struct packed {
        logic          fault;
        page_e         kind;
        logic [AW-1:0] pa;
        logic [1:0]    ap;
        logic          cache_en;
        logic          buff_en;
    } xlat_t;

    // Keep the upper bits of base above base_lsb, insert a word index from va.
    function automatic logic [AW-1:0] table_addr(input logic [AW-1:0] base,
                                                 input int base_lsb,
                                                 input logic [AW-1:0] va,
                                                 input int idx_lsb,
                                                 input int idx_w);
        logic [AW-1:0] hi_mask, idx_mask;
        hi_mask  = {AW{1'b1}} << base_lsb;
        idx_mask = ~({AW{1'b1}} << idx_w);
        return (base & hi_mask) | (((va >> idx_lsb) & idx_mask) << 2);
    endfunction

    // Splice a page frame from desc with the in-page offset of va.
    function automatic logic [AW-1:0] page_pa(input logic [DW-1:0] desc,
                                              input logic [AW-1:0] va,
                                              input int shift);
        logic [AW-1:0] hi_mask;
        hi_mask = {AW{1'b1}} << shift;
        return (desc & hi_mask) | (va & ~hi_mask);
    endfunction
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [DW-1:0] desc,
    input  logic [AW-1:0] va,
    output logic          walk_on,
    output logic [AW-1:0] next_addr,
    output xlat_t         res
);
    always_comb begin
        res       = '0;
        walk_on   = 1'b0;
        next_addr = '0;
        case (l1_kind_e'(desc[1:0]))
            L1_EMPTY: res.fault = 1'b1;
            L1_SECTION: begin
                res.kind     = PG_SECTION;
                res.pa       = page_pa(desc, va, SEC_SHIFT);
                res.ap       = desc[11:10];
                res.cache_en = desc[3];
                res.buff_en  = desc[2];
            end
            L1_COARSE: begin
                walk_on   = 1'b1;
                next_addr = table_addr(desc, CRS_BASE_LSB, va, CRS_IDX_LSB, CRS_IDX_W);
            end
            default: begin
                walk_on   = 1'b1;
                next_addr = table_addr(desc, FIN_BASE_LSB, va, FIN_IDX_LSB, FIN_IDX_W);
            end
        endcase
    end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [DW-1:0] desc,
    input  logic [AW-1:0] va,
    output xlat_t         res
);
    always_comb begin
        res = '0;
        if (l2_kind_e'(desc[1:0]) == L2_EMPTY) begin
            res.fault = 1'b1;
        end else begin
            res.ap       = desc[5:4];
            res.cache_en = desc[3];
            res.buff_en  = desc[2];
            case (l2_kind_e'(desc[1:0]))
                L2_LARGE: begin
                    res.kind = PG_LARGE;
                    res.pa   = page_pa(desc, va, LRG_SHIFT);
                end
                L2_SMALL: begin
                    res.kind = PG_SMALL;
                    res.pa   = page_pa(desc, va, SML_SHIFT);
                end
                default: begin
                    res.kind = PG_TINY;
                    res.pa   = page_pa(desc, va, TNY_SHIFT);
                end
            endcase
        end
    end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_va,
    input  logic [AW-1:0] req_tbase,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          done,
    output logic          fault,
    output logic          fault_lvl,
    output logic [AW-1:0] res_pa,
    output logic [1:0]    res_kind,
    output logic [1:0]    res_ap,
    output logic          res_cacheable,
    output logic          res_bufferable
);
    walk_st_e      st;
    logic [AW-1:0] va_q;
    logic [AW-1:0] addr_q;
    xlat_t         res_q;
    logic          done_q;
    logic          lvl_q;

    logic          l1_walk_on;
    logic [AW-1:0] l1_next;
    xlat_t         l1_res;
    xlat_t         l2_res;

    ptw_l1_decode u_l1 (
        .desc      (mem_rsp_data),
        .va        (va_q),
        .walk_on   (l1_walk_on),
        .next_addr (l1_next),
        .res       (l1_res)
    );

    ptw_l2_decode u_l2 (
        .desc (mem_rsp_data),
        .va   (va_q),
        .res  (l2_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            va_q   <= '0;
            addr_q <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
            lvl_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va;
                    addr_q <= table_addr(req_tbase, L1_BASE_LSB, req_va, L1_IDX_LSB, L1_IDX_W);
                    st     <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_req_ready) st <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    if (l1_walk_on) begin
                        addr_q <= l1_next;
                        st     <= ST_L2_REQ;
                    end else begin
                        res_q  <= l1_res;
                        lvl_q  <= 1'b0;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                ST_L2_REQ: if (mem_req_ready) st <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    res_q  <= l2_res;
                    lvl_q  <= l2_res.fault;
                    done_q <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign req_ready      = (st == ST_IDLE);
    assign mem_req_valid  = (st == ST_L1_REQ) || (st == ST_L2_REQ);
    assign mem_req_addr   = addr_q;
    assign done           = done_q;
    assign fault          = res_q.fault;
    assign fault_lvl      = lvl_q;
    assign res_pa         = res_q.pa;
    assign res_kind       = res_q.kind;
    assign res_ap         = res_q.ap;
    assign res_cacheable  = res_q.cache_en;
    assign res_bufferable = res_q.buff_en;
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk
    import ptw_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr,
    input logic          done,
    input logic          fault,
    input logic [AW-1:0] res_pa,
    input logic [1:0]    res_kind,
    input logic [AW-1:0] va_q
);
    // R10
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> !req_ready);
    // R10
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    // R11
    pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R11
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        done && fault |-> res_pa == '0 && res_kind == 2'd0);
    // R3
    sect_off_chk: assert property (@(posedge clk) disable iff (rst)
        done && !fault && res_kind == PG_SECTION |-> res_pa[19:0] == va_q[19:0]);
    // R7
    large_off_chk: assert property (@(posedge clk) disable iff (rst)
        done && !fault && res_kind == PG_LARGE |-> res_pa[15:0] == va_q[15:0]);
    // R8
    small_off_chk: assert property (@(posedge clk) disable iff (rst)
        done && !fault && res_kind == PG_SMALL |-> res_pa[11:0] == va_q[11:0]);
    // R9
    tiny_off_chk: assert property (@(posedge clk) disable iff (rst)
        done && !fault && res_kind == PG_TINY |-> res_pa[9:0] == va_q[9:0]);
endmodule

bind ptw_top ptw_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .done          (done),
    .fault         (fault),
    .res_pa        (res_pa),
    .res_kind      (res_kind),
    .va_q          (va_q)
);

// File: tb/tb_ptw_top.sv
module tb_ptw_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] req_tbase = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done, fault, fault_lvl, res_cacheable, res_bufferable;
    logic [31:0] res_pa;
    logic [1:0]  res_kind, res_ap;

    always #5 clk = ~clk;

    ptw_top dut (.*);

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_addr [$];
    string       cur_tag = "";
    bit          pend = 0;
    logic        e_fault, e_lvl, e_c, e_b;
    logic [1:0]  e_kind, e_ap;
    logic [31:0] e_pa;
    int          lat = 0;
    logic [31:0] lat_addr = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: arithmetic walk over the memory array.
    task automatic model(input logic [31:0] va, input logic [31:0] tb);
        logic [31:0] a1, a2, d1, d2;
        e_fault = 0; e_lvl = 0; e_kind = 0; e_ap = 0; e_pa = 0; e_c = 0; e_b = 0;
        a1 = (tb & 32'hFFFF_C000) + ((va >> 20) * 4);
        exp_addr.push_back(a1);
        d1 = rd(a1);
        if (d1[1:0] == 2'b00) begin
            e_fault = 1;
        end else if (d1[1:0] == 2'b10) begin
            e_pa = (d1 & 32'hFFF0_0000) + (va % 32'h0010_0000);
            e_ap = d1[11:10]; e_c = d1[3]; e_b = d1[2];
        end else begin
            if (d1[1:0] == 2'b01) a2 = (d1 & 32'hFFFF_FC00) + (((va >> 12) % 256) * 4);
            else                  a2 = (d1 & 32'hFFFF_F000) + (((va >> 10) % 1024) * 4);
            exp_addr.push_back(a2);
            d2 = rd(a2);
            case (d2[1:0])
                2'b00: begin e_fault = 1; e_lvl = 1; end
                2'b01: begin e_kind = 1; e_pa = (d2 & 32'hFFFF_0000) + (va % 32'h1_0000); end
                2'b10: begin e_kind = 2; e_pa = (d2 & 32'hFFFF_F000) + (va % 32'h1000); end
                default: begin e_kind = 3; e_pa = (d2 & 32'hFFFF_FC00) + (va % 32'h400); end
            endcase
            if (!e_fault) begin e_ap = d2[5:4]; e_c = d2[3]; e_b = d2[2]; end
        end
    endtask

    // Memory, responder and per-cycle comparison, all on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            mem_rsp_valid = 1'b0;
            if (lat > 0) begin
                lat--;
                if (lat == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = rd(lat_addr);
                end
            end
            mem_req_ready = (cyc % 3) != 1;
            if (mem_req_valid && mem_req_ready) begin
                if (exp_addr.size() == 0) begin
                    chk(cur_tag, mem_req_addr, 32'hxxxx_xxxx, "unexpected read (R2/R3)");
                end else begin
                    chk(exp_addr.size() == 2 ? "R1" : cur_tag, mem_req_addr,
                        exp_addr.pop_front(), "read address");
                end
                lat_addr = mem_req_addr;
                lat = 1 + (cyc % 3);
            end
            if (done) begin
                if (!pend) begin
                    chk("R11", 32'(done), 32'd0, "done without request");
                end else begin
                    chk(cur_tag, 32'(fault), 32'(e_fault), "fault");
                    chk(cur_tag, 32'(fault_lvl), 32'(e_lvl), "fault_lvl");
                    chk(cur_tag, res_pa, e_pa, "pa");
                    chk(cur_tag, 32'(res_kind), 32'(e_kind), "kind");
                    chk(cur_tag, 32'(res_ap), 32'(e_ap), "ap");
                    chk(cur_tag, 32'({res_cacheable, res_bufferable}), 32'({e_c, e_b}), "c/b");
                    chk("R2", 32'(exp_addr.size()), 32'd0, "reads left at done");
                    exp_addr.delete();
                    pend = 0;
                end
            end
        end
    end

    task automatic walk(input string tag, input logic [31:0] va, input logic [31:0] tb);
        bit ok;
        int wd = 0;
        cur_tag = tag;
        model(va, tb);
        pend = 1;
        req_va = va; req_tbase = tb; req_valid = 1'b1;
        forever begin
            ok = req_ready;
            @(negedge clk);
            if (ok) break;
        end
        req_valid = 1'b0;
        req_va = 32'hDEAD_BEEF; req_tbase = 32'hFFFF_FFFF;
        chk("R10", 32'(req_ready), 32'd0, "ready while busy");
        while (pend && wd < 200) begin
            @(negedge clk);
            wd++;
        end
        if (pend) begin
            chk(tag, 32'd0, 32'd1, "walk timeout");
            pend = 0;
            exp_addr.delete();
        end
    endtask

    initial begin
        // first-level table at 0x0010_0000, second-level tables further up
        mem[32'h0010_0000 + 32'h123 * 4] = 32'hABC0_0C0A; // section ap=3 C
        mem[32'h0010_0000 + 32'h7FF * 4] = 32'h0010_0406; // section ap=1 B
        mem[32'h0010_0000 + 32'h300 * 4] = 32'h0020_0401; // coarse
        mem[32'h0010_0000 + 32'h400 * 4] = 32'h0030_1003; // fine
        mem[32'h0020_0400 + 32'hAB * 4]  = 32'h5555_602A; // small
        mem[32'h0020_0400 + 32'hCD * 4]  = 32'h7777_0015; // large
        mem[32'h0020_0400 + 32'h01 * 4]  = 32'h1234_5C3F; // tiny
        mem[32'h0030_1000 + 32'h08D * 4] = 32'h6666_7002; // small
        mem[32'h0030_1000 + 32'h3FF * 4] = 32'hAAAA_A433; // tiny
        mem[32'h0030_1000 + 32'h015 * 4] = 32'hBEEF_000D; // large
        mem[32'h0FFF_C000 + 32'hFFF * 4] = 32'hFFF0_0002; // section, top entry

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", 32'(req_ready), 32'd1, "reset ready");
        chk("R11", 32'(done), 32'd0, "reset done");
        chk("R10", 32'(mem_req_valid), 32'd0, "reset mem request");

        walk("R3", 32'h1234_5678, 32'h0010_0000);
        walk("R3", 32'h7FF0_0001, 32'h0010_2ABC); // R1: low base bits ignored
        walk("R2", 32'h2000_0000, 32'h0010_0000);
        walk("R8", 32'h300A_B123, 32'h0010_3FFF); // R4 coarse small
        walk("R7", 32'h300C_DEF1, 32'h0010_0000); // R4 coarse large
        walk("R9", 32'h3000_13A5, 32'h0010_0000); // R4 coarse tiny
        walk("R6", 32'h300F_F000, 32'h0010_0000);
        walk("R5", 32'h4002_3456, 32'h0010_0000); // fine small
        walk("R9", 32'h400F_FC12, 32'h0010_0000); // R5 fine tiny
        walk("R7", 32'h4000_5678, 32'h0010_0000); // R5 fine large
        walk("R6", 32'h4000_0000, 32'h0010_0000); // fine, empty entry
        walk("R1", 32'hFFFF_FFFF, 32'h0FFF_C000);
        walk("R11", 32'h2000_0000, 32'h0010_0000); // fault after success clears fields

        repeat (5) @(negedge clk);
        chk("R11", 32'(done), 32'd0, "no stray done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule